// File: doc/BRIEF.md
# GF(2) Matrix Multiplier with Result History

This block is the linear layer of a cipher-oriented processor extension. It multiplies a 32-bit source word by a 32×32 bit matrix over GF(2), so AND takes the place of multiply and XOR takes the place of add. Loaded with a permuted identity matrix it becomes a bit permutation. Loaded with a denser matrix it becomes a diffusion layer. The matrix sits in a 1024-bit register. Software fills that register by shifting in 1 to 16 bits of an immediate per load operation, so a full fill takes 64 loads of 16 bits.

Each multiply can push its result into a four-word history array. A later multiply can XOR one of those four stored words into its own product. This lets the column or word mixing of a cipher round be built from several products. The result is combinational from the source, the matrix and the history. Pushes into the history and loads into the matrix take effect at the next rising clock edge.

The reset input is asynchronous and active low. Inside the block its release passes through two flops before the registers leave reset.

Top module: `gf2_linear_layer`

## Requirements
- R1: After reset the matrix and all four history entries are zero, so the result is zero for any source, select and accumulate setting.
- R2: Matrix row r occupies register bits [1023-32r : 992-32r], so row 0 is the most significant slice. Result bit 31-r is the XOR reduction of (row r AND source), with row bit j paired with source bit j.
- R3: A cycle with the load strobe high shifts the matrix register left by n bits and places the n most significant bits of the 16-bit immediate in the low n bits. n is the 4-bit count, and a count of 0 means n = 16.
- R4: Sixty-four full-width loads replace the whole matrix. The first word loaded ends in the upper half of row 0, and the last word loaded ends in the lower half of row 31.
- R5: In a cycle with the mac strobe high and the load strobe low, the returned value is pushed into history entry 0. Entries 0, 1 and 2 move to entries 1, 2 and 3, and the old entry 3 is discarded. Entry 0 is the newest entry.
- R6: With the accumulate flag high, the result is the product XOR one history entry. Select 0 picks entry 3, select 1 picks entry 0, select 2 picks entry 1, and select 3 picks entry 2. With the flag low, the result is the plain product.
- R7: When accumulate and push fall in the same cycle, the sum uses the entry as it stood before that cycle's push, and the pushed word is that sum.
- R8: With the mac strobe low, the history is left unchanged, even when the accumulate flag is high.
- R9: A load cycle leaves the history unchanged even when the mac strobe is high. A cycle with the load strobe low leaves the matrix unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Shift-load the matrix register this cycle |
| ld_count | input | 4 | Number of immediate bits to insert (0 means 16) |
| ld_imm | input | 16 | Immediate whose top bits are inserted |
| src | input | 32 | Source vector for the multiply |
| mac_en | input | 1 | Push the returned value into the history |
| acc_en | input | 1 | XOR the selected history entry into the product |
| hist_sel | input | 2 | History select code, mapped as in R6 |
| result | output | 32 | Product, or product XOR the selected entry |

## Verification
The matrix and the history have no read port, so the hardest cases to reach are those where their state must be checked after a push, a load or an ignored strobe. Two probes read the state out through the result. A zero source gives a zero product, so an accumulate with each select shows each history entry directly. A one-hot source on bit j shows column j of the matrix. Sweeps of these probes run after every kind of operation. They include a load with the mac strobe high, an accumulate with no push, and an accumulate with a push in the same cycle, which must use the entry read before the shift.

// File: rtl/gf2_lin_pkg.sv
package gf2_lin_pkg;

  // Operation applied at the next clock edge.
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_LOAD = 2'd1,
    OP_PUSH = 2'd2
  } gf2_op_e;

  // Decide what a cycle does. A load takes priority over a push.
  function automatic gf2_op_e decode_op(input logic ld, input logic mac);
    if (ld)       return OP_LOAD;
    else if (mac) return OP_PUSH;
    else          return OP_IDLE;
  endfunction

endpackage

// File: rtl/gf2_matrix_reg.sv
module gf2_matrix_reg #(
  parameter int VEC_W = 32,
  parameter int IMM_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ld_en,
  input  logic [$clog2(IMM_W)-1:0]     ld_count,
  input  logic [IMM_W-1:0]             ld_imm,
  output logic [VEC_W*VEC_W-1:0]       mat_q
);

  localparam int MAT_W = VEC_W * VEC_W;
  localparam int CNT_W = $clog2(IMM_W);

  // One candidate per possible insert length 1..IMM_W.
  logic [MAT_W-1:0] cand [IMM_W];
  logic [CNT_W-1:0] cand_idx;
  logic [MAT_W-1:0] mat_d;

  for (genvar gk = 1; gk <= IMM_W; gk++) begin : g_shift
    assign cand[gk-1] = {mat_q[MAT_W-1-gk:0], ld_imm[IMM_W-1 -: gk]};
  end

  // Count k selects candidate k-1. A count of zero wraps to the full width.
  assign cand_idx = ld_count - CNT_W'(1);

  always_comb begin
    mat_d = mat_q;
    if (ld_en) mat_d = cand[cand_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mat_q <= '0;
    else if (ld_en) mat_q <= mat_d;
  end

  // R3: a single-bit load lands the immediate's top bit in bit 0.
  a_r3_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_count == CNT_W'(1)) |=> mat_q[0] == $past(ld_imm[IMM_W-1]));

  // R3: a count of zero inserts the whole immediate and shifts the rest up.
  a_r3_full_word: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_count == '0) |=>
      (mat_q[IMM_W-1:0] == $past(ld_imm)) &&
      (mat_q[MAT_W-1:IMM_W] == $past(mat_q[MAT_W-1-IMM_W:0])));

  // R9: without a load the matrix holds.
  a_r9_matrix_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> $stable(mat_q));

endmodule

// File: rtl/gf2_matvec.sv
module gf2_matvec #(
  parameter int VEC_W = 32
) (
  input  logic [VEC_W*VEC_W-1:0] mat,
  input  logic [VEC_W-1:0]       src,
  output logic [VEC_W-1:0]       prod
);

  localparam int MAT_W = VEC_W * VEC_W;

  // Row r is the r-th slice from the top and drives result bit VEC_W-1-r.
  for (genvar gr = 0; gr < VEC_W; gr++) begin : g_row
    logic [VEC_W-1:0] row;
    assign row               = mat[MAT_W-1-gr*VEC_W -: VEC_W];
    assign prod[VEC_W-1-gr]  = ^(row & src);
  end

endmodule

// File: rtl/gf2_hist_array.sv
module gf2_hist_array #(
  parameter int VEC_W = 32,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_en,
  input  logic [VEC_W-1:0]           push_data,
  input  logic [$clog2(DEPTH)-1:0]   rd_sel,
  output logic [VEC_W-1:0]           rd_data
);

  localparam int SEL_W = $clog2(DEPTH);

  logic [DEPTH-1:0][VEC_W-1:0] ent_q;
  logic [DEPTH-1:0][VEC_W-1:0] ent_d;
  logic [SEL_W-1:0]            rd_idx;

  // Entry 0 is the newest. A push shifts toward DEPTH-1 and drops the oldest.
  always_comb begin
    ent_d = ent_q;
    if (push_en) begin
      ent_d[0] = push_data;
      for (int k = 1; k < DEPTH; k++) ent_d[k] = ent_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ent_q <= '0;
    else if (push_en) ent_q <= ent_d;
  end

  // Select code s reads entry (s-1) mod DEPTH, so code 0 reads the oldest entry.
  assign rd_idx  = rd_sel - SEL_W'(1);
  assign rd_data = ent_q[rd_idx];

  // R5: the pushed word becomes entry 0.
  a_r5_push_head: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |=> ent_q[0] == $past(push_data));

  // R5: the oldest slot receives its neighbour on a push.
  a_r5_push_tail: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |=> ent_q[DEPTH-1] == $past(ent_q[DEPTH-2]));

  // R8: without a push every entry holds.
  a_r8_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !push_en |=> $stable(ent_q));

endmodule

// File: rtl/gf2_linear_layer.sv
module gf2_linear_layer
  import gf2_lin_pkg::*;
#(
  parameter int VEC_W = 32,
  parameter int IMM_W = 16,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ld_en,
  input  logic [$clog2(IMM_W)-1:0]   ld_count,
  input  logic [IMM_W-1:0]           ld_imm,
  input  logic [VEC_W-1:0]           src,
  input  logic                       mac_en,
  input  logic                       acc_en,
  input  logic [$clog2(DEPTH)-1:0]   hist_sel,
  output logic [VEC_W-1:0]           result
);

  localparam int MAT_W = VEC_W * VEC_W;

  // The asynchronous assert is released through two flops.
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  gf2_op_e          op;
  logic             push_en;
  logic [MAT_W-1:0] mat_q;
  logic [VEC_W-1:0] prod;
  logic [VEC_W-1:0] hist_word;

  assign op      = decode_op(ld_en, mac_en);
  assign push_en = (op == OP_PUSH);

  gf2_matrix_reg #(.VEC_W(VEC_W), .IMM_W(IMM_W)) i_matrix (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .ld_en    (op == OP_LOAD),
    .ld_count (ld_count),
    .ld_imm   (ld_imm),
    .mat_q    (mat_q)
  );

  gf2_matvec #(.VEC_W(VEC_W)) i_matvec (
    .mat  (mat_q),
    .src  (src),
    .prod (prod)
  );

  gf2_hist_array #(.VEC_W(VEC_W), .DEPTH(DEPTH)) i_hist (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .push_en   (push_en),
    .push_data (result),
    .rd_sel    (hist_sel),
    .rd_data   (hist_word)
  );

  // The entry is read before this cycle's push updates the array.
  assign result = prod ^ (acc_en ? hist_word : '0);

  // R2: a zero source gives a zero product, so the result is the selected entry or zero.
  a_r2_zero_source: assert property (@(posedge clk) disable iff (!core_rst_n)
    (src == '0 && !acc_en) |-> result == '0);

  // R9: a load cycle never disturbs the history, even with the mac strobe high.
  a_r9_load_no_push: assert property (@(posedge clk) disable iff (!core_rst_n)
    (ld_en && mac_en) |=> $stable(i_hist.ent_q));

endmodule

// File: tb/test_gf2_linear_layer.sv
module test_gf2_linear_layer;

  localparam int CLK_PERIOD = 10;
  localparam int VW = 32;
  localparam int IW = 16;
  localparam int MW = VW * VW;
  localparam int WATCHDOG = 200000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ld_en;
  logic [3:0]    ld_count;
  logic [IW-1:0] ld_imm;
  logic [VW-1:0] src;
  logic          mac_en;
  logic          acc_en;
  logic [1:0]    hist_sel;
  logic [VW-1:0] result;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [MW-1:0] m_model;
  logic [VW-1:0] h_model [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  gf2_linear_layer i_gf2_linear_layer (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_count(ld_count),
    .ld_imm(ld_imm), .src(src), .mac_en(mac_en), .acc_en(acc_en),
    .hist_sel(hist_sel), .result(result)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Matrix-vector product over GF(2) as the requirement states it.
  function automatic logic [VW-1:0] mv(input logic [MW-1:0] m, input logic [VW-1:0] s);
    logic [VW-1:0] o;
    for (int r = 0; r < VW; r++) o[VW-1-r] = ^(m[MW-1-VW*r -: VW] & s);
    return o;
  endfunction

  function automatic int sel_to_entry(input logic [1:0] s);
    return (int'(s) + 3) % 4;
  endfunction

  task automatic check(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic ld, input logic [3:0] cnt, input logic [IW-1:0] imm,
                       input logic [VW-1:0] s, input logic mac, input logic acc,
                       input logic [1:0] sel);
    @(negedge clk);
    ld_en = ld; ld_count = cnt; ld_imm = imm; src = s;
    mac_en = mac; acc_en = acc; hist_sel = sel;
    #1;
  endtask

  task automatic do_op(input logic [VW-1:0] s, input logic mac, input logic acc,
                       input logic [1:0] sel, input string tag);
    logic [VW-1:0] exp;
    drive(1'b0, 4'd0, '0, s, mac, acc, sel);
    exp = mv(m_model, s) ^ (acc ? h_model[sel_to_entry(sel)] : '0);
    check(tag, result, exp);
    if (mac) begin
      for (int k = 3; k > 0; k--) h_model[k] = h_model[k-1];
      h_model[0] = exp;
    end
  endtask

  task automatic do_load(input logic [3:0] cnt, input logic [IW-1:0] imm, input logic mac);
    int n;
    logic [MW-1:0] ins;
    drive(1'b1, cnt, imm, $urandom, mac, 1'b0, 2'd0);
    n = (cnt == 0) ? IW : int'(cnt);
    ins = {{(MW-IW){1'b0}}, imm} >> (IW - n);
    m_model = (m_model << n) | ins;
  endtask

  task automatic load_matrix(input logic [MW-1:0] t);
    for (int w = 0; w < MW/IW; w++) do_load(4'd0, t[MW-1-IW*w -: IW], 1'b0);
  endtask

  task automatic probe_matrix(input string tag);
    for (int j = 0; j < VW; j++) do_op(32'd1 << j, 1'b0, 1'b0, 2'd0, tag);
    for (int k = 0; k < 8; k++) do_op($urandom, 1'b0, 1'b0, 2'd0, tag);
  endtask

  task automatic read_hist(input string tag);
    for (int s = 0; s < 4; s++) do_op('0, 1'b0, 1'b1, 2'(s), tag);
  endtask

  initial begin
    logic [MW-1:0] t;
    logic [VW-1:0] s;
    rst_n = 1'b0; ld_en = 1'b0; ld_count = '0; ld_imm = '0; src = '0;
    mac_en = 1'b0; acc_en = 1'b0; hist_sel = '0;
    m_model = '0;
    for (int k = 0; k < 4; k++) h_model[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: everything zero after reset.
    for (int k = 0; k < 4; k++) begin
      drive(1'b0, 4'd0, '0, $urandom, 1'b0, 1'b1, 2'(k));
      check("R1 reset result", result, '0);
    end

    // R4: identity through 64 full loads gives result == source.
    t = '0;
    for (int r = 0; r < VW; r++) t[MW-1-VW*r -: VW] = 32'h8000_0000 >> r;
    load_matrix(t);
    for (int k = 0; k < 24; k++) begin
      s = $urandom;
      drive(1'b0, 4'd0, '0, s, 1'b0, 1'b0, 2'd0);
      check("R4 identity", result, s);
    end
    probe_matrix("R2 identity columns");

    // R4: bit-reversal permutation.
    t = '0;
    for (int r = 0; r < VW; r++) t[MW-1-VW*r -: VW] = 32'd1 << r;
    load_matrix(t);
    for (int k = 0; k < 8; k++) begin
      s = $urandom;
      drive(1'b0, 4'd0, '0, s, 1'b0, 1'b0, 2'd0);
      check("R4 reversal", result, {<<{s}});
    end

    // R2: dense random matrices.
    for (int m = 0; m < 4; m++) begin
      for (int w = 0; w < MW/32; w++) t[32*w +: 32] = $urandom;
      load_matrix(t);
      probe_matrix("R2 random matrix");
    end

    // R3: every count value, including 0 meaning 16.
    for (int rep = 0; rep < 4; rep++) begin
      for (int c = 0; c < 16; c++) do_load(4'(c), IW'($urandom), 1'b0);
      probe_matrix("R3 partial loads");
    end

    // R5: pushes fill entry 0 and shift toward 3.
    for (int k = 0; k < 6; k++) do_op($urandom, 1'b1, 1'b0, 2'd0, "R5 push");
    read_hist("R5 history contents");

    // R6: select mapping with a nonzero product.
    for (int k = 0; k < 16; k++) do_op($urandom, 1'b0, 1'b1, 2'(k % 4), "R6 accumulate");

    // R7: accumulate and push in one cycle.
    for (int k = 0; k < 12; k++) do_op($urandom, 1'b1, 1'b1, 2'(k % 4), "R7 read before push");
    read_hist("R7 pushed sums");

    // R8: accumulate without mac leaves the history alone.
    for (int k = 0; k < 8; k++) do_op($urandom, 1'b0, 1'b1, 2'(k % 4), "R8 no push result");
    read_hist("R8 history unchanged");

    // R9: loads with mac high do not push; the matrix holds across other ops.
    for (int k = 0; k < 6; k++) do_load(4'(k), IW'($urandom), 1'b1);
    read_hist("R9 history after load");
    probe_matrix("R9 matrix after load");
    for (int k = 0; k < 4; k++) do_op($urandom, 1'b1, 1'b1, 2'(k), "R9 ops");
    probe_matrix("R9 matrix held");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule